// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a small bank of hardware semaphores that several processor cores use to coordinate access to shared resources. Each semaphore records a lock bit together with the owner's 4-bit core ID and 8-bit process ID. A core can take a semaphore in two ways. In the two-step method it writes a lock request and then reads the register back to see whether it won. In the one-step method a single read of a separate read-lock register takes the semaphore and reports the result in the same access.

Only the recorded owner can release a semaphore. A keyed clear frees every semaphore held by one core in a single access. Each core has its own interrupt enable, status and write-1-to-clear registers, and these report semaphores that have become free.

The bus carries one access per cycle, and every access carries the ID of the requesting core. Read data is combinational and reflects the effect of the access being made.

Top module: `hw_semaphore_bank`

## Requirements
- R1: After reset every semaphore is free and its lock register reads 0. All enable and status bits read 0, the key register reads 0 and every irq line is low.
- R2: A write to lock register 0x00+i (i = 0..5) with bit 31 = 1, core ID in [11:8] and process ID in [7:0] takes semaphore i if it is free. Reading that register then returns bit 31 = 1 with the stored core ID and process ID.
- R3: A lock write with bit 31 = 1 to a semaphore that is already held leaves its owner fields unchanged.
- R4: A read of read-lock register 0x08+i on a free semaphore takes it with the requesting core's ID and process ID 0, and the read returns that new owner word. On a held semaphore the read returns the stored owner and changes nothing.
- R5: A write of bit 31 = 0 to lock register 0x00+i frees the semaphore only if both the written core ID and the written process ID match the stored owner. Any other such write is ignored.
- R6: A write to the clear register 0x18, with the key in [31:16] and a core ID in [11:8], frees every semaphore held by that core ID when the key equals the key register. A wrong key changes nothing, and semaphores held by other cores are never affected.
- R7: The key register at 0x19 holds a 16-bit value in [15:0] that can be written and read back.
- R8: Core c (c = 0 or 1) has an enable register at 0x10+4c, a status register at 0x12+4c and a clear register at 0x11+4c, with bit i belonging to semaphore i. When semaphore i goes from locked to free, status bit i is set for every core whose enable bit i is set. A release write to a semaphore that is already free sets no status bit.
- R9: irq[c] is high exactly when core c's status ANDed with its enable is non-zero. Writing a 1 to bit i of the clear register clears only status bit i.
- R10: Accesses are served one per cycle. When two cores try in successive accesses to take the same free semaphore, only the first succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_master | input | 4 | Core ID of the requesting master |
| bus_rdata | output | 32 | Read data for the current access |
| irq | output | 2 | Per-core semaphore-freed interrupt |

## Verification
The bench concentrates on contention and ownership corner cases.

- A second lock write to a held semaphore must not overwrite the owner. A design that gets this wrong lets the later requester also pass its verify read.
- Release writes that match only the core ID, or only the process ID, must be ignored. A design that checks just one field frees a semaphore belonging to someone else.
- A bulk clear with a wrong key must leave everything locked, and a correct key must free only the named core's semaphores. Errors here either free everything or free nothing.
- A release of an already-free semaphore must raise no status bit, and the write-1-to-clear register must clear only the bits written. A wrong design gives spurious or sticky interrupts.

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank #(
  parameter int NUM_SEM  = 6,
  parameter int NUM_CORE = 2,
  parameter int CID_W    = 4,
  parameter int PID_W    = 8,
  parameter int KEY_W    = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CID_W-1:0]  bus_master,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CORE-1:0] irq
);
  localparam int LOCK_BIT = DATA_W - 1;
  localparam int CID_LO   = PID_W;
  localparam int CID_HI   = PID_W + CID_W - 1;
  localparam int KEY_LO   = DATA_W - KEY_W;
  localparam logic [2:0] GRP_LOCK  = 3'd0;
  localparam logic [2:0] GRP_RLOCK = 3'd1;
  localparam logic [2:0] GRP_IRQ   = 3'd2;
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(25);

  logic [NUM_SEM-1:0] lock_q;
  logic [CID_W-1:0]   cid_q [NUM_SEM];
  logic [PID_W-1:0]   pid_q [NUM_SEM];
  logic [NUM_SEM-1:0] ier_q [NUM_CORE];
  logic [NUM_SEM-1:0] isr_q [NUM_CORE];
  logic [KEY_W-1:0]   key_q;

  logic [2:0] grp, idx;
  assign grp = bus_addr[5:3];
  assign idx = bus_addr[2:0];

  logic             w_lock;
  logic [CID_W-1:0] w_cid;
  logic [PID_W-1:0] w_pid;
  logic [KEY_W-1:0] w_key;
  assign w_lock = bus_wdata[LOCK_BIT];
  assign w_cid  = bus_wdata[CID_HI:CID_LO];
  assign w_pid  = bus_wdata[PID_W-1:0];
  assign w_key  = bus_wdata[DATA_W-1:KEY_LO];

  logic lock_wr, rlock_rd, clr_wr, key_wr, irq_acc;
  assign lock_wr  = bus_en && bus_we  && grp == GRP_LOCK;
  assign rlock_rd = bus_en && !bus_we && grp == GRP_RLOCK;
  assign clr_wr   = bus_en && bus_we  && bus_addr == CLR_ADDR;
  assign key_wr   = bus_en && bus_we  && bus_addr == KEY_ADDR;
  assign irq_acc  = bus_en && grp == GRP_IRQ;

  function automatic logic [DATA_W-1:0] pack(logic l, logic [CID_W-1:0] c, logic [PID_W-1:0] p);
    logic [DATA_W-1:0] w;
    w = '0;
    w[LOCK_BIT] = l;
    w[CID_HI:CID_LO] = c;
    w[PID_W-1:0] = p;
    return w;
  endfunction

  logic [NUM_SEM-1:0] take2, take1, rel;
  always_comb begin
    take2 = '0;
    take1 = '0;
    rel   = '0;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (lock_wr && idx == 3'(i)) begin
        if (w_lock && !lock_q[i]) take2[i] = 1'b1;
        if (!w_lock && lock_q[i] && cid_q[i] == w_cid && pid_q[i] == w_pid) rel[i] = 1'b1;
      end
      if (rlock_rd && idx == 3'(i) && !lock_q[i]) take1[i] = 1'b1;
      if (clr_wr && w_key == key_q && lock_q[i] && cid_q[i] == w_cid) rel[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      key_q  <= '0;
      for (int i = 0; i < NUM_SEM; i++) begin
        cid_q[i] <= '0;
        pid_q[i] <= '0;
      end
    end else begin
      if (key_wr) key_q <= bus_wdata[KEY_W-1:0];
      for (int i = 0; i < NUM_SEM; i++) begin
        if (take2[i]) begin
          lock_q[i] <= 1'b1;
          cid_q[i]  <= w_cid;
          pid_q[i]  <= w_pid;
        end else if (take1[i]) begin
          lock_q[i] <= 1'b1;
          cid_q[i]  <= bus_master;
          pid_q[i]  <= '0;
        end else if (rel[i]) begin
          lock_q[i] <= 1'b0;
          cid_q[i]  <= '0;
          pid_q[i]  <= '0;
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic sel, ier_wr, icr_wr;
    assign sel    = irq_acc && idx[2] == 1'(c);
    assign ier_wr = sel && bus_we && idx[1:0] == 2'd0;
    assign icr_wr = sel && bus_we && idx[1:0] == 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ier_q[c] <= '0;
        isr_q[c] <= '0;
      end else begin
        if (ier_wr) ier_q[c] <= bus_wdata[NUM_SEM-1:0];
        isr_q[c] <= (isr_q[c] & ~(icr_wr ? bus_wdata[NUM_SEM-1:0] : '0)) | (rel & ier_q[c]);
      end
    end

    assign irq[c] = |(isr_q[c] & ier_q[c]);

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
      AST_FREE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_q[i]) && ier_q[c][i]) |-> isr_q[c][i]); // R8
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (grp == GRP_LOCK && int'(idx) < NUM_SEM)
        bus_rdata = pack(lock_q[idx], cid_q[idx], pid_q[idx]);
      else if (grp == GRP_RLOCK && int'(idx) < NUM_SEM)
        bus_rdata = lock_q[idx] ? pack(1'b1, cid_q[idx], pid_q[idx]) : pack(1'b1, bus_master, '0);
      else if (grp == GRP_IRQ && int'(idx[2]) < NUM_CORE) begin
        if (idx[1:0] == 2'd0) bus_rdata = DATA_W'(ier_q[idx[2]]);
        else if (idx[1:0] == 2'd2) bus_rdata = DATA_W'(isr_q[idx[2]]);
      end else if (bus_addr == KEY_ADDR)
        bus_rdata = DATA_W'(key_q);
    end
  end

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
    AST_HELD_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[i] && lock_wr && idx == 3'(i) && w_lock) |=> (lock_q[i] && $stable(cid_q[i]) && $stable(pid_q[i]))); // R3
    AST_READ_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q[i] && rlock_rd && idx == 3'(i)) |=> (lock_q[i] && cid_q[i] == $past(bus_master) && pid_q[i] == '0)); // R4
    AST_FOREIGN_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[i] && lock_wr && idx == 3'(i) && !w_lock && (cid_q[i] != w_cid || pid_q[i] != w_pid) && !clr_wr) |=> lock_q[i]); // R5
    AST_FREE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q[i] |-> (cid_q[i] == '0 && pid_q[i] == '0)); // R1
  end

  AST_BAD_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && w_key != key_q) |=> $stable(lock_q)); // R6
endmodule

// File: tb/tb_hw_semaphore_bank.sv
module tb_hw_semaphore_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] C0 = 4'h4;
  localparam logic [3:0] C1 = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_master = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_tests = 0, n_fail = 0;

  hw_semaphore_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_master(bus_master),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word(logic l, logic [3:0] c, logic [7:0] p);
    return {l, 19'd0, c, p};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_master = m;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [3:0] m, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_master = m;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      rd(6'(i), C0, d); check("R1 sem free", d, 0);
    end
    rd(6'h10, C0, d); check("R1 ier0", d, 0);
    rd(6'h16, C0, d); check("R1 isr1", d, 0);
    rd(6'h19, C0, d); check("R1 key", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_two_step();
    logic [31:0] d;
    wr(6'h02, word(1, C0, 8'h11), C0);
    rd(6'h02, C0, d); check("R2 verify read", d, word(1, C0, 8'h11));
    wr(6'h02, word(1, C1, 8'h22), C1);
    rd(6'h02, C1, d); check("R3 held owner kept", d, word(1, C0, 8'h11));
    wr(6'h02, word(0, C0, 8'h12), C0);
    rd(6'h02, C0, d); check("R5 pid mismatch ignored", d, word(1, C0, 8'h11));
    wr(6'h02, word(0, C1, 8'h11), C1);
    rd(6'h02, C0, d); check("R5 cid mismatch ignored", d, word(1, C0, 8'h11));
    wr(6'h02, word(0, C0, 8'h11), C0);
    rd(6'h02, C0, d); check("R5 owner release", d, 0);
  endtask

  task automatic t_one_step();
    logic [31:0] d;
    rd(6'h0D, C1, d); check("R4 read-lock return", d, word(1, C1, 0));
    rd(6'h05, C0, d); check("R4 stored owner", d, word(1, C1, 0));
    rd(6'h0D, C0, d); check("R10 second taker loses", d, word(1, C1, 0));
    rd(6'h05, C0, d); check("R4 held unchanged", d, word(1, C1, 0));
    wr(6'h05, word(0, C1, 0), C1);
    rd(6'h05, C0, d); check("R5 release one-step", d, 0);
  endtask

  task automatic t_key_bulk();
    logic [31:0] d;
    wr(6'h19, 32'h0000_5A5A, C0);
    rd(6'h19, C0, d); check("R7 key readback", d, 32'h5A5A);
    wr(6'h00, word(1, C0, 8'h01), C0);
    wr(6'h01, word(1, C0, 8'h02), C0);
    wr(6'h03, word(1, C1, 8'h03), C1);
    wr(6'h18, {16'h1234, 4'd0, C0, 8'd0}, C0);
    rd(6'h00, C0, d); check("R6 bad key keeps sem0", d, word(1, C0, 8'h01));
    rd(6'h01, C0, d); check("R6 bad key keeps sem1", d, word(1, C0, 8'h02));
    wr(6'h18, {16'h5A5A, 4'd0, C0, 8'd0}, C1);
    rd(6'h00, C0, d); check("R6 bulk frees sem0", d, 0);
    rd(6'h01, C0, d); check("R6 bulk frees sem1", d, 0);
    rd(6'h03, C0, d); check("R6 other core kept", d, word(1, C1, 8'h03));
    wr(6'h03, word(0, C1, 8'h03), C1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(6'h10, 32'h0000_0024, C0);
    wr(6'h14, 32'h0000_0020, C1);
    wr(6'h02, word(1, C0, 8'h44), C0);
    wr(6'h05, word(1, C1, 8'h55), C1);
    check("R9 no irq while held", 32'(irq), 0);
    wr(6'h02, word(0, C0, 8'h44), C0);
    rd(6'h12, C0, d); check("R8 core0 status", d, 32'h04);
    rd(6'h16, C1, d); check("R8 core1 disabled", d, 0);
    check("R9 irq core0 only", 32'(irq), 2'b01);
    wr(6'h05, word(0, C1, 8'h55), C1);
    rd(6'h12, C0, d); check("R8 core0 status both", d, 32'h24);
    rd(6'h16, C1, d); check("R8 core1 status", d, 32'h20);
    check("R9 both irq", 32'(irq), 2'b11);
    wr(6'h11, 32'h04, C0);
    rd(6'h12, C0, d); check("R9 w1c only bit2", d, 32'h20);
    wr(6'h11, 32'h20, C0);
    wr(6'h15, 32'h20, C1);
    check("R9 irq cleared", 32'(irq), 0);
    wr(6'h02, word(0, C0, 8'h44), C0);
    rd(6'h12, C0, d); check("R8 free release no status", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_two_step();
    t_one_step();
    t_key_bulk();
    t_irq();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule